// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block takes one 32-bit single-precision floating-point operand and turns it into a signed integer, either 32 or 64 bits wide depending on a size-select input. The fractional part is removed according to a 2-bit rounding-mode input. Each operation reports two exception flags: an invalid flag, for NaN, infinity or a result that does not fit, and a precision flag, for an inexact conversion.

The block is a two-stage pipeline. The first stage aligns the significand to the integer binary point and collects the guard and sticky bits. The second stage rounds, checks the range and forms the result. An operation presented with `in_valid` high comes out exactly two clock cycles later. If an operation is invalid and the invalid mask input is set, the block returns a fixed indefinite pattern. If the mask is clear, the block raises a fault strobe and drops the result strobe for that operation.

Top module: `fp2int_conv`

## Requirements
- R1: While reset is low and on the first cycle after it, `out_valid`, `out_fault`, `out_invalid`, `out_precision` and `out_result` are all zero.
- R2: An operation accepted with `in_valid` high yields exactly one output strobe (`out_valid` or `out_fault`) two cycles later. Without an accepted operation, neither strobe rises.
- R3: With `in_wide` = 0 the result is the operand rounded to a signed 32-bit integer in `out_result[31:0]`, with `out_result[63:32]` zero. Rounding mode encoding: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R4: With `in_wide` = 1 the full 64-bit `out_result` is the operand rounded to a signed 64-bit integer, using the same rounding encoding.
- R5: A rounded value outside the signed range of the selected width raises `out_invalid`. When masked (`in_inv_mask` = 1), the result is 0x0000_0000_8000_0000 in 32-bit mode or 0x8000_0000_0000_0000 in 64-bit mode.
- R6: An operand with exponent field (bits 30:23) all ones, meaning NaN or infinity of either sign, always raises `out_invalid`.
- R7: `out_precision` is high exactly when the operand has discarded nonzero fraction bits and the operation is not invalid. The two flags are never high together.
- R8: An invalid operation with `in_inv_mask` = 0 asserts `out_fault` and `out_invalid` with `out_valid` low and `out_result` zero.
- R9: Zero and denormal operands give 0, or +1/-1 when the rounding direction rounds away from zero. A negative value that rounds to zero gives plain 0. Any nonzero denormal sets `out_precision`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_operand | input | 32 | Single-precision operand |
| in_wide | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| in_rmode | input | 2 | Rounding mode (00 nearest-even, 01 down, 10 up, 11 toward zero) |
| in_inv_mask | input | 1 | 1 returns indefinite on invalid, 0 faults |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Converted integer |
| out_invalid | output | 1 | Invalid exception flag |
| out_precision | output | 1 | Inexact exception flag |
| out_fault | output | 1 | Unmasked invalid, result suppressed |

## Verification
A corrupted alignment shift or a lost guard or sticky bit shows up as a wrong integer or a wrong precision flag on the same operation, two cycles after it enters. A bad range limit shows up at the power-of-two boundaries (plus and minus 2^31 and 2^63), where the result strobe and the fault strobe swap or the indefinite pattern is missing. Random operands with exponents around the integer range are checked on every cycle, together with directed ties, denormals, signed zeros and specials. Because of this, any internal fault becomes visible within two cycles of the operation that triggers it.

// File: rtl/fp2int_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the float-to-integer converter.
// Assumes IEEE-754 single-precision input and at most a 64-bit result.
package fp2int_pkg;
    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int BIAS    = 127;
    localparam int INT_W   = 64;
    localparam int NARROW_W = 32;
    // Exponent at which the significand LSB has weight 1.
    localparam logic [EXP_W-1:0] EXP_UNIT = EXP_W'(BIAS + FRAC_W);
    // Largest left shift that still fits the significand in INT_W bits.
    localparam logic [EXP_W-1:0] LSH_MAX  = EXP_W'(INT_W - SIG_W);
    // Largest useful right shift (beyond it everything is sticky).
    localparam logic [EXP_W-1:0] RSH_MAX  = EXP_W'(SIG_W + 2);
    localparam int ALIGN_W = SIG_W + SIG_W + 2;
    localparam logic [INT_W-1:0] INDEF_WIDE   = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] INDEF_NARROW = INT_W'({1'b1, {(NARROW_W-1){1'b0}}});

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic             sign;
        logic             special;   // NaN or infinity
        logic             huge;      // magnitude at or beyond 2^INT_W
        logic [INT_W-1:0] mag;       // truncated integer magnitude
        logic             guard;     // first discarded bit
        logic             sticky;    // OR of the remaining discarded bits
    } align_t;
endpackage

// File: rtl/fp2int_align.sv
`timescale 1ns/1ps
// Alignment stage: moves the significand to the integer binary point and
// produces the truncated magnitude with guard and sticky bits.
// Assumes denormals keep no hidden bit; their tiny weight only feeds sticky.
module fp2int_align
    import fp2int_pkg::*;
(
    input  logic [FP_W-1:0] op,
    output align_t          al
);
    logic [EXP_W-1:0]   exp_f;
    logic [SIG_W-1:0]   sig;
    logic [EXP_W-1:0]   lsh;
    logic [EXP_W-1:0]   rsh;
    logic [ALIGN_W-1:0] shifted;

    assign exp_f = op[FP_W-2 -: EXP_W];
    assign sig   = {exp_f != '0, op[FRAC_W-1:0]};
    assign lsh   = exp_f - EXP_UNIT;
    assign rsh   = EXP_UNIT - exp_f;

    // Select left or right alignment from the exponent and gather round bits.
    always_comb begin
        al         = '0;
        al.sign    = op[FP_W-1];
        al.special = (exp_f == '1);
        shifted    = '0;
        if (exp_f >= EXP_UNIT) begin
            if (lsh > LSH_MAX) begin
                al.huge = 1'b1;
            end else begin
                al.mag = INT_W'(sig) << lsh[5:0];
            end
        end else if (rsh > RSH_MAX) begin
            al.sticky = |sig;
        end else begin
            shifted   = {sig, {(SIG_W+2){1'b0}}} >> rsh[4:0];
            al.mag    = INT_W'(shifted[ALIGN_W-1 -: SIG_W]);
            al.guard  = shifted[SIG_W+1];
            al.sticky = |shifted[SIG_W:0];
        end
    end
endmodule

// File: rtl/fp2int_round.sv
`timescale 1ns/1ps
// Rounding stage: applies the rounding mode, checks the signed range of the
// selected width and forms the two's-complement result or the indefinite value.
// Assumes the alignment stage flagged every magnitude beyond 64 bits as huge.
module fp2int_round
    import fp2int_pkg::*;
(
    input  align_t           al,
    input  logic             wide,
    input  logic [1:0]       rmode,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    logic             lost;
    logic             bump;
    logic [INT_W:0]   mag_r;
    logic [INT_W:0]   limit;
    logic             range_bad;
    logic [INT_W-1:0] signed_val;

    assign lost = al.guard | al.sticky;

    // Decide whether the magnitude is incremented under the current mode.
    always_comb begin
        case (rmode_e'(rmode))
            RM_NEAR: bump = al.guard & (al.sticky | al.mag[0]);
            RM_DOWN: bump = al.sign & lost;
            RM_UP:   bump = ~al.sign & lost;
            default: bump = 1'b0;
        endcase
    end

    assign mag_r = {1'b0, al.mag} + (INT_W+1)'(bump);
    assign limit = wide ? ((INT_W+1)'(1) << (INT_W-1)) : ((INT_W+1)'(1) << (NARROW_W-1));

    // Negative side may reach the limit itself; positive side must stay below.
    always_comb begin
        if (al.sign) range_bad = (mag_r > limit);
        else         range_bad = (mag_r >= limit);
    end

    assign invalid    = al.special | al.huge | range_bad;
    assign inexact    = ~invalid & lost;
    assign signed_val = al.sign ? (~mag_r[INT_W-1:0] + INT_W'(1)) : mag_r[INT_W-1:0];

    // Choose indefinite, full-width or zero-extended narrow result.
    always_comb begin
        if (invalid)   result = wide ? INDEF_WIDE : INDEF_NARROW;
        else if (wide) result = signed_val;
        else           result = INT_W'(signed_val[NARROW_W-1:0]);
    end
endmodule

// File: rtl/fp2int_conv.sv
`timescale 1ns/1ps
// Top of the float-to-integer converter: two-stage pipeline, alignment in
// stage one and rounding/range/result selection in stage two.
// Assumes one operation per cycle at most, no back-pressure.
module fp2int_conv
    import fp2int_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FP_W-1:0]  in_operand,
    input  logic             in_wide,
    input  logic [1:0]       in_rmode,
    input  logic             in_inv_mask,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_invalid,
    output logic             out_precision,
    output logic             out_fault
);
    align_t           al_c;
    align_t           s1_al;
    logic             s1_valid;
    logic             s1_wide;
    logic [1:0]       s1_rmode;
    logic             s1_mask;
    logic [INT_W-1:0] rnd_result;
    logic             rnd_invalid;
    logic             rnd_inexact;
    logic             faulting;

    fp2int_align i_align (
        .op (in_operand),
        .al (al_c)
    );

    // Stage-one register: aligned operand plus its controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_al    <= '0;
            s1_wide  <= 1'b0;
            s1_rmode <= 2'b00;
            s1_mask  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_al    <= in_valid ? al_c : '0;
            s1_wide  <= in_wide;
            s1_rmode <= in_rmode;
            s1_mask  <= in_inv_mask;
        end
    end

    fp2int_round i_round (
        .al      (s1_al),
        .wide    (s1_wide),
        .rmode   (s1_rmode),
        .result  (rnd_result),
        .invalid (rnd_invalid),
        .inexact (rnd_inexact)
    );

    assign faulting = s1_valid & rnd_invalid & ~s1_mask;

    // Stage-two register: result, flags and the result-or-fault strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_fault     <= 1'b0;
            out_result    <= '0;
            out_invalid   <= 1'b0;
            out_precision <= 1'b0;
        end else begin
            out_valid     <= s1_valid & ~faulting;
            out_fault     <= faulting;
            out_result    <= (s1_valid & ~faulting) ? rnd_result : '0;
            out_invalid   <= s1_valid & rnd_invalid;
            out_precision <= s1_valid & rnd_inexact;
        end
    end
endmodule

// File: rtl/fp2int_chk.sv
`timescale 1ns/1ps
// Property checker for fp2int_conv, attached through bind.
// Assumes the two-cycle latency of the top module.
module fp2int_chk
    import fp2int_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [FP_W-1:0]  in_operand,
    input logic             in_wide,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result,
    input logic             out_invalid,
    input logic             out_precision,
    input logic             out_fault
);
    AST_NO_DUAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) !(out_invalid && out_precision)); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(out_valid && out_fault)); // R8
    AST_FAULT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) out_fault |-> (out_invalid && out_result == '0)); // R8
    AST_STROBE_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid || out_fault) |-> $past(in_valid, 2)); // R2
    AST_OP_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $past(in_valid, 2) |-> (out_valid || out_fault)); // R2
    AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n) $past(in_valid && in_operand[FP_W-2 -: EXP_W] == '1, 2) |-> out_invalid); // R6
    AST_INDEF_PATTERN: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_invalid) |-> (out_result == ($past(in_wide, 2) ? INDEF_WIDE : INDEF_NARROW))); // R5
endmodule

bind fp2int_conv fp2int_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_operand    (in_operand),
    .in_wide       (in_wide),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_invalid   (out_invalid),
    .out_precision (out_precision),
    .out_fault     (out_fault)
);

// File: tb/test_fp2int_conv.sv
`timescale 1ns/1ps
// Bench for fp2int_conv: directed corners plus seeded random operands,
// compared against a wide fixed-point reference model.
module test_fp2int_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        in_wide = 1'b0;
    logic [1:0]  in_rmode = 2'b00;
    logic        in_inv_mask = 1'b1;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_precision;
    logic        out_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic        v;
        logic        f;
        logic        inv;
        logic        prec;
        logic [63:0] res;
        logic [31:0] op;
        logic        wide;
        logic        valid_in;
    } exp_t;

    exp_t d1 = '0;
    exp_t d2 = '0;

    always #2.5 clk = ~clk;

    fp2int_conv i_fp2int_conv (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_operand    (in_operand),
        .in_wide       (in_wide),
        .in_rmode      (in_rmode),
        .in_inv_mask   (in_inv_mask),
        .out_valid     (out_valid),
        .out_result    (out_result),
        .out_invalid   (out_invalid),
        .out_precision (out_precision),
        .out_fault     (out_fault)
    );

    // Reference: value = sig * 2^(e-150) held exactly with 150 fraction bits.
    function automatic exp_t model(input logic vin, input logic [31:0] op,
                                   input logic wide, input logic [1:0] rm,
                                   input logic mask);
        exp_t        e;
        logic [7:0]  ex;
        logic [23:0] sig;
        logic [279:0] x;
        logic [129:0] ip;
        logic [149:0] fr;
        logic [149:0] half;
        logic [129:0] lim;
        logic         up;
        logic         inexact;
        logic         inv;
        logic [63:0]  val;
        int           sh;
        e = '0;
        e.op = op;
        e.wide = wide;
        e.valid_in = vin;
        if (!vin) return e;
        ex  = op[30:23];
        sig = {ex != 0, op[22:0]};
        sh  = (ex == 0) ? 1 : int'(ex);
        x   = 280'(sig) << sh;
        ip  = x[279:150];
        fr  = x[149:0];
        half = 150'd1 << 149;
        inexact = (fr != 0);
        case (rm)
            2'b00: up = (fr > half) || (fr == half && ip[0]);
            2'b01: up = op[31] && inexact;
            2'b10: up = !op[31] && inexact;
            default: up = 1'b0;
        endcase
        ip  = ip + 130'(up);
        lim = wide ? (130'd1 << 63) : (130'd1 << 31);
        inv = (ex == 8'hFF) || (op[31] ? (ip > lim) : (ip >= lim));
        val = op[31] ? (64'd0 - ip[63:0]) : ip[63:0];
        if (!wide) val = {32'd0, val[31:0]};
        if (inv) val = wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
        e.inv  = inv;
        e.prec = !inv && inexact;
        e.f    = inv && !mask;
        e.v    = !e.f;
        e.res  = e.f ? 64'd0 : val;
        return e;
    endfunction

    // Pick the requirement a given expectation exercises.
    function automatic string req_of(input exp_t e);
        if (!e.valid_in) return "R2";
        if (e.f) return "R8";
        if (e.inv && e.op[30:23] == 8'hFF) return "R6";
        if (e.inv) return "R5";
        if (e.op[30:23] == 8'h00) return "R9";
        if (e.prec) return "R7";
        if (e.wide) return "R4";
        return "R3";
    endfunction

    // Compare outputs against the expectation of two cycles ago.
    task automatic check_out(input exp_t e);
        checks++;
        if (out_valid !== e.v || out_fault !== e.f || out_invalid !== e.inv ||
            out_precision !== e.prec || out_result !== e.res) begin
            fails++;
            $display("FAIL %s op=%h wide=%0b got v=%0b f=%0b inv=%0b prec=%0b res=%h exp v=%0b f=%0b inv=%0b prec=%0b res=%h",
                     req_of(e), e.op, e.wide, out_valid, out_fault, out_invalid, out_precision,
                     out_result, e.v, e.f, e.inv, e.prec, e.res);
        end
    endtask

    // One cycle: check, advance the expectation line, drive the next input.
    task automatic step(input logic v, input logic [31:0] op, input logic w,
                        input logic [1:0] rm, input logic m);
        @(negedge clk);
        check_out(d2);
        d2 = d1;
        d1 = model(v, op, w, rm, m);
        in_valid = v; in_operand = op; in_wide = w; in_rmode = rm; in_inv_mask = m;
    endtask

    task automatic all_modes(input logic [31:0] op, input logic w, input logic m);
        for (int r = 0; r < 4; r++) step(1'b1, op, w, 2'(r), m);
    endtask

    localparam logic [31:0] DIRECTED [0:21] = '{
        32'h3F80_0000, 32'h3FC0_0000, 32'h4020_0000, 32'hC020_0000,
        32'h3F00_0000, 32'hBF00_0000, 32'h0000_0000, 32'h8000_0000,
        32'h0000_0001, 32'h8000_0001, 32'h4F00_0000, 32'hCF00_0000,
        32'h4EFF_FFFF, 32'hCF00_0001, 32'h5F00_0000, 32'hDF00_0000,
        32'h5EFF_FFFF, 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000,
        32'h3EFF_FFFF, 32'h4B7F_FFFF
    };

    initial begin
        logic [31:0] op;
        logic [7:0]  ex;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        checks++;
        if (out_valid !== 1'b0 || out_fault !== 1'b0 || out_invalid !== 1'b0 ||
            out_precision !== 1'b0 || out_result !== 64'd0) begin
            fails++;
            $display("FAIL R1 reset state got v=%0b f=%0b res=%h exp all zero", out_valid, out_fault, out_result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still quiet on the first cycle after reset
        checks++;
        if (out_valid !== 1'b0 || out_fault !== 1'b0 || out_result !== 64'd0) begin
            fails++;
            $display("FAIL R1 after reset got v=%0b f=%0b res=%h exp 0 0 0", out_valid, out_fault, out_result);
        end
        // Directed corners in both widths, every mode, masked and unmasked.
        for (int i = 0; i < 22; i++) begin
            all_modes(DIRECTED[i], 1'b0, 1'b1);
            all_modes(DIRECTED[i], 1'b1, 1'b1);
            step(1'b1, DIRECTED[i], 1'b0, 2'b00, 1'b0);
            step(1'b1, DIRECTED[i], 1'b1, 2'b11, 1'b0);
        end
        // R2: idle gap produces no strobes
        repeat (4) step(1'b0, 32'h4000_0000, 1'b0, 2'b00, 1'b1);
        // Random operands, exponents biased toward the integer range.
        for (int i = 0; i < 6000; i++) begin
            op = $urandom;
            if ($urandom_range(0, 3) != 0) begin
                ex = 8'(100 + $urandom_range(0, 95));
                op[30:23] = ex;
            end
            step($urandom_range(0, 7) != 0, op, 1'($urandom), 2'($urandom),
                 $urandom_range(0, 4) != 0);
        end
        repeat (3) step(1'b0, 32'h0, 1'b0, 2'b00, 1'b1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got running exp finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule